// File: doc/BRIEF.md
# Decimal Nibble Rotate Unit

This block performs the two four-bit digit rotations of an eight-bit accumulator machine. A rotation moves three nibbles around a ring formed by the low nibble of the accumulator and both nibbles of one memory byte. The accumulator's upper nibble takes no part and is returned as it came in. The unit takes the accumulator, the incoming flag byte and a byte address. It fetches the memory byte, computes the new accumulator, the byte to store and the new flags, and then stores that byte back at the same address.

An operation begins with a one-cycle `start` pulse, which also samples the direction, the accumulator, the flags and the address. The unit then makes one read request on a simple request/acknowledge memory port. After that it makes one write request. A one-cycle `done` pulse marks the point where the results are valid. The flag byte uses the usual layout: sign in bit 7, zero in bit 6, copies of result bits 5 and 3 in bits 5 and 3, half-carry in bit 4, parity in bit 2, subtract in bit 1 and carry in bit 0. The unit also reports the instruction's fixed cycle cost so that the surrounding core can keep time.

Top module: `nibble_rot_unit`

## Requirements
- R1: With `dir_left`=0 (rotate right), for accumulator A and memory byte M the stored byte is {A[3:0], M[7:4]} and the new accumulator low nibble is M[3:0].
- R2: With `dir_left`=1 (rotate left), the stored byte is {M[3:0], A[3:0]} and the new accumulator low nibble is M[7:4].
- R3: The new accumulator's bits 7:4 equal the sampled accumulator's bits 7:4 in both directions.
- R4: `tstates` reports 18 for either direction.
- R5: In `flags_out`, bit 7 equals new A[7] and bit 6 is set exactly when the new A is zero. Bit 5 equals A[5] and bit 3 equals A[3]. Bit 2 is set when A has an even number of ones. Bits 4 and 1 are zero.
- R6: `flags_out` bit 0 equals bit 0 of the sampled `flags_in`. The other incoming flag bits have no effect.
- R7: After a start the unit raises `mem_req` with `mem_we`=0 at the sampled address and holds it until `mem_ack`. Only after that read is acknowledged does it raise `mem_req` with `mem_we`=1. The write uses the same address and is held until `mem_ack`.
- R8: `done` is high for exactly one cycle, the cycle after the write is acknowledged. `busy` is high from the cycle after the start through the `done` cycle, and low after it.
- R9: A `start` pulse while `busy` is high is ignored: the running operation's results are those of the inputs sampled at its own start.
- R10: After reset, `busy`, `done` and `mem_req` are low, and `acc_out` and `flags_out` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| dir_left | input | 1 | 0 = rotate right, 1 = rotate left |
| acc_in | input | 8 | Accumulator value |
| flags_in | input | 8 | Incoming flag byte (only bit 0 used) |
| addr_in | input | ADDR_W | Address of the memory byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Byte to store |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` on a read |
| mem_ack | input | 1 | Request accepted this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 8 | New accumulator |
| flags_out | output | 8 | New flag byte |
| tstates | output | 5 | Cycle cost of the instruction |

## Verification
The hardest case to reach is a second `start` that arrives while the unit is still waiting for a slow read acknowledge. It carries a different direction and accumulator, and it must leave the running rotation untouched. The bench holds off the read acknowledge for several cycles and pulses `start` with inverted inputs inside that window. It then compares the stored byte and the accumulator with the values expected from the original inputs. The vector walk varies the acknowledge latency from zero to five cycles, so the check that the write never begins before the read completes is exercised with back-to-back and stretched handshakes.

// File: rtl/rot_pkg.sv
package rot_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } seq_e;

    typedef enum logic {
        DIR_RIGHT = 1'b0,
        DIR_LEFT  = 1'b1
    } dir_e;

    // Bit order of this struct gives the flag byte layout.
    typedef struct packed {
        logic sgn;
        logic zer;
        logic cp5;
        logic hlf;
        logic cp3;
        logic par;
        logic sub;
        logic cry;
    } flags_t;

    typedef struct packed {
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] wbyte;
    } rot_res_t;

    function automatic flags_t make_flags(input logic [BYTE_W-1:0] a, input logic c);
        flags_t f;
        f.sgn = a[BYTE_W-1];
        f.zer = (a == '0);
        f.cp5 = a[5];
        f.hlf = 1'b0;
        f.cp3 = a[3];
        f.par = ~(^a);
        f.sub = 1'b0;
        f.cry = c;
        return f;
    endfunction

endpackage

// File: rtl/rot_route.sv
module rot_route
    import rot_pkg::*;
(
    input  dir_e               dir,
    input  logic [BYTE_W-1:0]  acc,
    input  logic [BYTE_W-1:0]  mem,
    output rot_res_t           res
);
    logic [NIB_W-1:0] a_lo, a_hi, m_lo, m_hi;

    assign a_lo = acc[NIB_W-1:0];
    assign a_hi = acc[BYTE_W-1:NIB_W];
    assign m_lo = mem[NIB_W-1:0];
    assign m_hi = mem[BYTE_W-1:NIB_W];

    always_comb begin
        res.acc[BYTE_W-1:NIB_W] = a_hi;
        if (dir == DIR_LEFT) begin
            res.acc[NIB_W-1:0] = m_hi;
            res.wbyte          = {m_lo, a_lo};
        end else begin
            res.acc[NIB_W-1:0] = m_lo;
            res.wbyte          = {a_lo, m_hi};
        end
    end
endmodule

// File: rtl/rot_flags.sv
module rot_flags
    import rot_pkg::*;
(
    input  logic [BYTE_W-1:0] acc,
    input  logic              carry,
    output flags_t            flags
);
    assign flags = make_flags(acc, carry);
endmodule

// File: rtl/rot_seq.sv
module rot_seq
    import rot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic mem_ack,
    output seq_e state,
    output logic accept,
    output logic cap_rd,
    output logic done
);
    seq_e state_n;

    assign accept = (state == ST_IDLE) && start;
    assign cap_rd = (state == ST_READ) && mem_ack;
    assign done   = (state == ST_DONE);

    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:  if (start)   state_n = ST_READ;
            ST_READ:  if (mem_ack) state_n = ST_WRITE;
            ST_WRITE: if (mem_ack) state_n = ST_DONE;
            ST_DONE:               state_n = ST_IDLE;
            default:               state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

    // R8: done follows an acknowledged write
    a_r8_done_after_write: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(state == ST_WRITE && mem_ack));
    // R8: done lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7: the write phase is only entered from the read phase
    a_r7_write_after_read: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE) && $changed(state) |-> $past(state == ST_READ && mem_ack));
endmodule

// File: rtl/nibble_rot_unit.sv
module nibble_rot_unit
    import rot_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int T_STATES = 18,
    localparam int TS_W    = $clog2(T_STATES + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dir_left,
    input  logic [7:0]        acc_in,
    input  logic [7:0]        flags_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done,
    output logic [7:0]        acc_out,
    output logic [7:0]        flags_out,
    output logic [TS_W-1:0]   tstates
);
    seq_e              state;
    logic              accept, cap_rd;
    dir_e              dir_q;
    logic [BYTE_W-1:0] acc_q;
    logic              carry_q;
    logic [ADDR_W-1:0] addr_q;
    rot_res_t          res_c, res_q;
    flags_t            flags_c, flags_q;

    rot_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mem_ack (mem_ack),
        .state   (state),
        .accept  (accept),
        .cap_rd  (cap_rd),
        .done    (done)
    );

    rot_route u_route (
        .dir (dir_q),
        .acc (acc_q),
        .mem (mem_rdata),
        .res (res_c)
    );

    rot_flags u_flags (
        .acc   (res_c.acc),
        .carry (carry_q),
        .flags (flags_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= DIR_RIGHT;
            acc_q   <= '0;
            carry_q <= 1'b0;
            addr_q  <= '0;
            res_q   <= '0;
            flags_q <= '0;
        end else begin
            if (accept) begin
                dir_q   <= dir_e'(dir_left);
                acc_q   <= acc_in;
                carry_q <= flags_in[0];
                addr_q  <= addr_in;
            end
            if (cap_rd) begin
                res_q   <= res_c;
                flags_q <= flags_c;
            end
        end
    end

    assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
    assign mem_we    = (state == ST_WRITE);
    assign mem_addr  = addr_q;
    assign mem_wdata = res_q.wbyte;
    assign busy      = (state != ST_IDLE);
    assign acc_out   = res_q.acc;
    assign flags_out = flags_q;
    assign tstates   = TS_W'(T_STATES);

    // R3: upper accumulator nibble returned unchanged
    a_r3_hi_kept: assert property (@(posedge clk) disable iff (rst)
        done |-> acc_out[7:4] == acc_q[7:4]);
    // R5: half-carry and subtract cleared
    a_r5_hn_clear: assert property (@(posedge clk) disable iff (rst)
        done |-> (flags_out[4] == 1'b0) && (flags_out[1] == 1'b0));
    // R6: carry passes through
    a_r6_carry_kept: assert property (@(posedge clk) disable iff (rst)
        done |-> flags_out[0] == carry_q);
    // R7: address held across a request
    a_r7_addr_held: assert property (@(posedge clk) disable iff (rst)
        mem_req && $past(mem_req) |-> $stable(mem_addr));
    // R9: a start while busy changes nothing sampled
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(acc_q) && $stable(dir_q) && $stable(addr_q));
endmodule

// File: tb/sim_nibble_rot_unit.sv
module sim_nibble_rot_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        start, dir_left, mem_ack;
    logic [7:0]  acc_in, flags_in, mem_rdata;
    logic [15:0] addr_in;
    logic        mem_req, mem_we, busy, done;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, acc_out, flags_out;
    logic [4:0]  tstates;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    nibble_rot_unit u0 (
        .clk(clk), .rst(rst), .start(start), .dir_left(dir_left),
        .acc_in(acc_in), .flags_in(flags_in), .addr_in(addr_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .done(done), .acc_out(acc_out),
        .flags_out(flags_out), .tstates(tstates)
    );

    // {acc, mem, flags_in, ctl}; ctl[0] = dir_left, ctl[3:1] = ack latency
    localparam logic [31:0] VEC [8] = '{
        32'h12_34_00_00, 32'h12_34_01_01, 32'hA5_5A_FE_03, 32'h80_00_01_04,
        32'h0F_F0_00_06, 32'h00_00_00_00, 32'hF0_0F_FF_09, 32'h7C_C3_00_0B
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_flags(input logic [7:0] a, input logic c);
        return {a[7], (a == 8'h00), a[5], 1'b0, a[3], ~(^a), 1'b0, c};
    endfunction

    task automatic wait_req(input logic we);
        int n = 0;
        while (!(mem_req === 1'b1 && mem_we === we) && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk("R7 request seen", {31'd0, mem_req}, 32'd1);
    endtask

    task automatic op(input logic dir, input logic [7:0] acc, input logic [7:0] mem,
                      input logic [7:0] flg, input int lat, input logic [15:0] addr,
                      input bit poke);
        logic [7:0] ea, ew;
        string tg;
        tg = dir ? "R2" : "R1";
        if (dir) begin
            ea = {acc[7:4], mem[7:4]};
            ew = {mem[3:0], acc[3:0]};
        end else begin
            ea = {acc[7:4], mem[3:0]};
            ew = {acc[3:0], mem[7:4]};
        end
        @(negedge clk);
        start = 1'b1; dir_left = dir; acc_in = acc; flags_in = flg; addr_in = addr;
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy after start", {31'd0, busy}, 32'd1);
        wait_req(1'b0);
        chk("R7 read address", {16'd0, mem_addr}, {16'd0, addr});
        for (int i = 0; i < lat; i++) begin
            if (poke && i == 0) begin
                start = 1'b1; dir_left = ~dir; acc_in = ~acc; addr_in = ~addr;
            end
            @(negedge clk);
            start = 1'b0;
            chk("R7 read held", {30'd0, mem_req, mem_we}, 32'd2);
        end
        mem_ack = 1'b1; mem_rdata = mem;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = 8'h00;
        wait_req(1'b1);
        chk("R7 write address", {16'd0, mem_addr}, {16'd0, addr});
        chk(poke ? "R9 stored byte" : tg, {24'd0, mem_wdata}, {24'd0, ew});
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk("R8 no early done", {31'd0, done}, 32'd0);
            chk("R7 write held", {30'd0, mem_req, mem_we}, 32'd3);
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        chk("R8 done after write", {31'd0, done}, 32'd1);
        chk(poke ? "R9 accumulator" : tg, {24'd0, acc_out}, {24'd0, ea});
        chk("R3 high nibble", {28'd0, acc_out[7:4]}, {28'd0, acc[7:4]});
        chk("R5 flags", {24'd0, flags_out[7:1]}, {24'd0, exp_flags(ea, 1'b0) >> 1});
        chk("R6 carry", {31'd0, flags_out[0]}, {31'd0, flg[0]});
        chk("R4 tstates", {27'd0, tstates}, 32'd18);
        @(negedge clk);
        chk("R8 done pulse ends", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; dir_left = 1'b0; mem_ack = 1'b0;
        acc_in = 8'h00; flags_in = 8'h00; mem_rdata = 8'h00; addr_in = 16'h0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset state", {27'd0, busy, done, mem_req, 2'b00}, 32'd0);
        chk("R10 reset outputs", {16'd0, acc_out, flags_out}, 32'd0);

        foreach (VEC[k]) begin
            op(VEC[k][0], VEC[k][31:24], VEC[k][23:16], VEC[k][15:8],
               int'(VEC[k][3:1]), 16'h1000 + 16'(k * 16'h0111), 1'b0);
        end

        // R9: start with inverted inputs during a slow read
        op(1'b0, 8'h3C, 8'h96, 8'h01, 4, 16'hBEEF, 1'b1);
        op(1'b1, 8'h3C, 8'h96, 8'h00, 3, 16'h4242, 1'b1);

        // R6: every other incoming flag bit has no effect
        op(1'b1, 8'h55, 8'hAA, 8'hFE, 0, 16'h0001, 1'b0);

        // R10: reset in the middle of an operation
        @(negedge clk);
        start = 1'b1; dir_left = 1'b0; acc_in = 8'h11; addr_in = 16'h2222;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset mid-op", {29'd0, busy, done, mem_req}, 32'd0);
        chk("R10 outputs after reset", {16'd0, acc_out, flags_out}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule